// File: doc/BRIEF.md
# Next Program Counter and Link Unit

This combinational unit picks the address of the next instruction for a 32-bit core whose instructions are all four bytes wide. It receives the current program counter, a 4-bit flow code produced by the decoder, the two source register values, the 16-bit immediate field and the 26-bit jump field. It returns the next program counter together with a link request and the link value meant for register 31.

A small control module turns the flow code and three compare flags into a select-and-link strobe struct. A datapath module computes the candidate addresses, the compare flags and the final selection. The core writes the link value into register 31 whenever the link request is high. Fetching, register writes and hazard handling are left to the surrounding pipeline.

Top module: `npcUnit`

## Requirements
- R1: Flow code 0 (sequential), and every unused code 12 to 15, gives pcNext = pcCur + 4 modulo 2^32 and linkEn = 0.
- R2: Code 1 (equal) and code 2 (not equal) compare all 32 bits of rsVal and rtVal. When the branch is taken, pcNext = pcCur + 4 + sign-extended imm16; otherwise pcNext = pcCur + 4. linkEn = 0.
- R3: Codes 3 (rsVal <= 0), 4 (rsVal > 0), 5 (rsVal < 0) and 6 (rsVal >= 0) treat rsVal as two's complement and branch to the same target as R2. linkEn = 0.
- R4: Code 7 (less than zero, with link) and code 8 (at least zero, with link) branch as in R3. They raise linkEn whether or not the branch is taken.
- R5: Code 9 (absolute jump) gives pcNext = {bits 31:28 of pcCur+4, jTarget, 2'b00}, with linkEn = 0.
- R6: Code 10 (jump with link) jumps to the same target as R5 and raises linkEn.
- R7: Code 11 (register jump) gives pcNext = rsVal, all 32 bits unchanged, with linkEn = 0.
- R8: linkVal always equals pcCur + 4 modulo 2^32, so it is 0 when pcCur is 0xFFFFFFFC.
- R9: With parameter WORD_OFFSET = 1, the branch offset is the sign-extended imm16 shifted left by 2. The default WORD_OFFSET = 0 uses it as a byte offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pcCur | input | 32 | Address of the current instruction |
| flowCode | input | 4 | Branch or jump kind from the decoder (codes as in R1 to R7) |
| rsVal | input | 32 | First source register value |
| rtVal | input | 32 | Second source register value |
| imm16 | input | 16 | Branch offset field |
| jTarget | input | 26 | Jump word-address field |
| pcNext | output | 32 | Address of the next instruction |
| linkEn | output | 1 | Request to write linkVal into register 31 |
| linkVal | output | 32 | Return address, pcCur + 4 |

## Verification
A branch-with-link instruction both redirects, or declines to redirect, the program counter and requests a link write in the same evaluation. The risk is that a design ties the link to a taken branch. The sweep drives codes 7 and 8 with rsVal values on both sides of zero, including 0, -1 and the most negative number. For every vector it judges pcNext against the taken or not-taken target and, independently, requires linkEn high and linkVal equal to pcCur + 4. Program counters near the top of the address space are included so that the link value and the branch target are also judged where they wrap.

// File: rtl/npcPkg.sv
package npcPkg;
  typedef enum logic [3:0] {
    FLOW_SEQ     = 4'd0,
    FLOW_EQ      = 4'd1,
    FLOW_NE      = 4'd2,
    FLOW_LEZ     = 4'd3,
    FLOW_GTZ     = 4'd4,
    FLOW_LTZ     = 4'd5,
    FLOW_GEZ     = 4'd6,
    FLOW_LTZ_LNK = 4'd7,
    FLOW_GEZ_LNK = 4'd8,
    FLOW_JABS    = 4'd9,
    FLOW_JLNK    = 4'd10,
    FLOW_JREG    = 4'd11
  } flowKind_e;

  typedef enum logic [1:0] {
    SEL_SEQ    = 2'd0,
    SEL_BRANCH = 2'd1,
    SEL_ABS    = 2'd2,
    SEL_REG    = 2'd3
  } pcSel_e;

  typedef struct packed {
    pcSel_e pcSel;
    logic   linkEn;
  } npcStrobes_t;
endpackage

// File: rtl/npcControl.sv
module npcControl
  import npcPkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] flowCode,
  input  logic              eqFlag,
  input  logic              negFlag,
  input  logic              zeroFlag,
  output npcStrobes_t       strobes
);
  logic posFlag;
  logic takeBr;

  assign posFlag = !negFlag && !zeroFlag;

  always_comb begin
    takeBr         = 1'b0;
    strobes.pcSel  = SEL_SEQ;
    strobes.linkEn = 1'b0;
    case (flowCode)
      FLOW_EQ:      takeBr = eqFlag;
      FLOW_NE:      takeBr = !eqFlag;
      FLOW_LEZ:     takeBr = negFlag || zeroFlag;
      FLOW_GTZ:     takeBr = posFlag;
      FLOW_LTZ:     takeBr = negFlag;
      FLOW_GEZ:     takeBr = !negFlag;
      FLOW_LTZ_LNK: begin
        takeBr         = negFlag;
        strobes.linkEn = 1'b1;
      end
      FLOW_GEZ_LNK: begin
        takeBr         = !negFlag;
        strobes.linkEn = 1'b1;
      end
      FLOW_JABS:    strobes.pcSel = SEL_ABS;
      FLOW_JLNK: begin
        strobes.pcSel  = SEL_ABS;
        strobes.linkEn = 1'b1;
      end
      FLOW_JREG:    strobes.pcSel = SEL_REG;
      default: begin
        takeBr         = 1'b0;
        strobes.pcSel  = SEL_SEQ;
        strobes.linkEn = 1'b0;
      end
    endcase
    if (takeBr) strobes.pcSel = SEL_BRANCH;
  end
endmodule

// File: rtl/npcDatapath.sv
module npcDatapath
  import npcPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IMM_W       = 16,
  parameter int TGT_W       = 26,
  parameter int INSTR_BYTES = 4,
  parameter bit WORD_OFFSET = 1'b0
) (
  input  logic [ADDR_W-1:0] pcCur,
  input  logic [ADDR_W-1:0] rsVal,
  input  logic [ADDR_W-1:0] rtVal,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [TGT_W-1:0]  jTarget,
  input  npcStrobes_t       strobes,
  output logic              eqFlag,
  output logic              negFlag,
  output logic              zeroFlag,
  output logic [ADDR_W-1:0] pcNext,
  output logic [ADDR_W-1:0] linkVal
);
  localparam int ALIGN_W = $clog2(INSTR_BYTES);
  localparam int REGION_W = ADDR_W - TGT_W - ALIGN_W;
  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] seqPc;
  logic [ADDR_W-1:0] immExt;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] branchPc;
  logic [ADDR_W-1:0] absPc;

  assign seqPc  = pcCur + ADDR_W'(INSTR_BYTES);
  assign immExt = {{EXT_W{imm16[IMM_W-1]}}, imm16};

  generate
    if (WORD_OFFSET) begin : g_wordOff
      assign offset = {immExt[ADDR_W-ALIGN_W-1:0], {ALIGN_W{1'b0}}};
    end else begin : g_byteOff
      assign offset = immExt;
    end
  endgenerate

  assign branchPc = seqPc + offset;
  assign absPc    = {seqPc[ADDR_W-1 -: REGION_W], jTarget, {ALIGN_W{1'b0}}};

  assign eqFlag   = (rsVal == rtVal);
  assign negFlag  = rsVal[ADDR_W-1];
  assign zeroFlag = (rsVal == '0);

  always_comb begin
    case (strobes.pcSel)
      SEL_BRANCH: pcNext = branchPc;
      SEL_ABS:    pcNext = absPc;
      SEL_REG:    pcNext = rsVal;
      default:    pcNext = seqPc;
    endcase
  end

  assign linkVal = seqPc;
endmodule

// File: rtl/npcUnit.sv
module npcUnit
  import npcPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IMM_W       = 16,
  parameter int TGT_W       = 26,
  parameter int CODE_W      = 4,
  parameter bit WORD_OFFSET = 1'b0
) (
  input  logic [ADDR_W-1:0] pcCur,
  input  logic [CODE_W-1:0] flowCode,
  input  logic [ADDR_W-1:0] rsVal,
  input  logic [ADDR_W-1:0] rtVal,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [TGT_W-1:0]  jTarget,
  output logic [ADDR_W-1:0] pcNext,
  output logic              linkEn,
  output logic [ADDR_W-1:0] linkVal
);
  npcStrobes_t strobes;
  logic eqFlag;
  logic negFlag;
  logic zeroFlag;

  npcControl #(.CODE_W(CODE_W)) uCtrl (
    .flowCode(flowCode),
    .eqFlag  (eqFlag),
    .negFlag (negFlag),
    .zeroFlag(zeroFlag),
    .strobes (strobes)
  );

  npcDatapath #(
    .ADDR_W     (ADDR_W),
    .IMM_W      (IMM_W),
    .TGT_W      (TGT_W),
    .INSTR_BYTES(4),
    .WORD_OFFSET(WORD_OFFSET)
  ) uPath (
    .pcCur   (pcCur),
    .rsVal   (rsVal),
    .rtVal   (rtVal),
    .imm16   (imm16),
    .jTarget (jTarget),
    .strobes (strobes),
    .eqFlag  (eqFlag),
    .negFlag (negFlag),
    .zeroFlag(zeroFlag),
    .pcNext  (pcNext),
    .linkVal (linkVal)
  );

  assign linkEn = strobes.linkEn;
endmodule

// File: rtl/npcUnitChecker.sv
module npcUnitChecker #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int TGT_W  = 26,
  parameter int CODE_W = 4
) (
  input logic [ADDR_W-1:0] pcCur,
  input logic [CODE_W-1:0] flowCode,
  input logic [ADDR_W-1:0] rsVal,
  input logic [ADDR_W-1:0] rtVal,
  input logic [IMM_W-1:0]  imm16,
  input logic [TGT_W-1:0]  jTarget,
  input logic [ADDR_W-1:0] pcNext,
  input logic              linkEn,
  input logic [ADDR_W-1:0] linkVal
);
  logic known;
  assign known = !$isunknown({pcCur, flowCode, rsVal, rtVal, imm16, jTarget});

  always_comb begin
    if (known) begin
      if (flowCode == 4'd0 || flowCode > 4'd11) begin
        a_r1_sequential: assert (!linkEn && pcNext == linkVal)
          else $error("R1 sequential flow redirected or linked");
      end
      if (flowCode == 4'd1 && rsVal != rtVal) begin
        a_r2_eq_not_taken: assert (pcNext == linkVal && !linkEn)
          else $error("R2 unequal operands took equal branch");
      end
      if (flowCode == 4'd7 || flowCode == 4'd8 || flowCode == 4'd10) begin
        a_r4_link_raised: assert (linkEn)
          else $error("R4/R6 link request missing");
      end
      if (flowCode == 4'd9 || flowCode == 4'd10) begin
        a_r5_abs_aligned: assert (pcNext[1:0] == 2'b00 &&
                                  pcNext[ADDR_W-1 -: 4] == linkVal[ADDR_W-1 -: 4] &&
                                  pcNext[TGT_W+1:2] == jTarget)
          else $error("R5 absolute jump target malformed");
      end
      if (flowCode == 4'd11) begin
        a_r7_reg_jump: assert (pcNext == rsVal && !linkEn)
          else $error("R7 register jump mismatch");
      end
      a_r8_link_value: assert (linkVal - pcCur == ADDR_W'(4))
        else $error("R8 link value not pc plus four");
    end
  end
endmodule

bind npcUnit npcUnitChecker #(
  .ADDR_W(ADDR_W), .IMM_W(IMM_W), .TGT_W(TGT_W), .CODE_W(CODE_W)
) uChk (
  .pcCur(pcCur), .flowCode(flowCode), .rsVal(rsVal), .rtVal(rtVal),
  .imm16(imm16), .jTarget(jTarget), .pcNext(pcNext), .linkEn(linkEn),
  .linkVal(linkVal)
);

// File: tb/sim_npcUnit.sv
module sim_npcUnit;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] pcCur;
  logic [3:0]  flowCode;
  logic [31:0] rsVal;
  logic [31:0] rtVal;
  logic [15:0] imm16;
  logic [25:0] jTarget;
  logic [31:0] pcNext0, linkVal0, pcNext1, linkVal1;
  logic        linkEn0, linkEn1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  npcUnit u0 (
    .pcCur(pcCur), .flowCode(flowCode), .rsVal(rsVal), .rtVal(rtVal),
    .imm16(imm16), .jTarget(jTarget), .pcNext(pcNext0), .linkEn(linkEn0),
    .linkVal(linkVal0)
  );

  npcUnit #(.WORD_OFFSET(1'b1)) u1 (
    .pcCur(pcCur), .flowCode(flowCode), .rsVal(rsVal), .rtVal(rtVal),
    .imm16(imm16), .jTarget(jTarget), .pcNext(pcNext1), .linkEn(linkEn1),
    .linkVal(linkVal1)
  );

  function automatic string tagOf(input logic [3:0] k);
    case (k)
      4'd1, 4'd2:       return "R2";
      4'd3, 4'd4, 4'd5, 4'd6: return "R3";
      4'd7, 4'd8:       return "R4";
      4'd9:             return "R5";
      4'd10:            return "R6";
      4'd11:            return "R7";
      default:          return "R1";
    endcase
  endfunction

  task automatic check32(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic runVector(input logic [31:0] pc, input logic [3:0] k,
                           input logic [31:0] rs, input logic [31:0] rt,
                           input logic [15:0] imm, input logic [25:0] tgt);
    logic [31:0] seq, offB, offW, expPc0, expPc1;
    logic        take, expLink;
    int signed   rsS;
    @(posedge clk);
    pcCur = pc; flowCode = k; rsVal = rs; rtVal = rt; imm16 = imm; jTarget = tgt;
    seq  = pc + 32'd4;
    offB = 32'($signed(imm));
    offW = offB * 32'd4;
    rsS  = $signed(rs);
    take = 1'b0;
    expLink = (k == 4'd7) || (k == 4'd8) || (k == 4'd10);
    case (k)
      4'd1: take = (rs == rt);
      4'd2: take = (rs != rt);
      4'd3: take = (rsS <= 0);
      4'd4: take = (rsS > 0);
      4'd5, 4'd7: take = (rsS < 0);
      4'd6, 4'd8: take = (rsS >= 0);
      default: take = 1'b0;
    endcase
    expPc0 = take ? seq + offB : seq;
    expPc1 = take ? seq + offW : seq;
    if (k == 4'd9 || k == 4'd10) begin
      expPc0 = (seq & 32'hF000_0000) | ({6'd0, tgt} * 32'd4);
      expPc1 = expPc0;
    end
    if (k == 4'd11) begin
      expPc0 = rs;
      expPc1 = rs;
    end
    @(negedge clk);
    check32(tagOf(k), "pcNext", pcNext0, expPc0);
    check32(expLink ? tagOf(k) : "R1/R2/R3/R5/R7 no link", "linkEn", {31'd0, linkEn0}, {31'd0, expLink});
    check32("R8", "linkVal", linkVal0, seq);
    check32("R9", "pcNext word offset", pcNext1, expPc1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] pcs [3];
    logic [31:0] vals [6];
    logic [15:0] imms [4];
    pcs[0] = 32'h0001_0008; pcs[1] = 32'hFFFF_FFFC; pcs[2] = 32'h7FFF_FFF0;
    vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h8000_0000; vals[4] = 32'h7FFF_FFFF; vals[5] = 32'h0000_0005;
    imms[0] = 16'h0000; imms[1] = 16'h0064; imms[2] = 16'hFFFC; imms[3] = 16'h8000;

    pcCur = 32'h0; flowCode = 4'd0; rsVal = 32'h0; rtVal = 32'h0;
    imm16 = 16'h0; jTarget = 26'h0;
    @(negedge clk);
    // R1 initial state: sequential code at pc 0
    check32("R1", "initial pcNext", pcNext0, 32'h4);
    check32("R1", "initial linkEn", {31'd0, linkEn0}, 32'd0);

    // R4 corner: not-taken branch with link still links
    runVector(32'h0040_0000, 4'd7, 32'h0000_0003, 32'h0, 16'h0010, 26'h0);
    // R8 wrap
    runVector(32'hFFFF_FFFC, 4'd0, 32'h0, 32'h0, 16'h0, 26'h0);
    // R6 jump with link to 0x0FAB8 region
    runVector(32'h0001_0008, 4'd10, 32'h0, 32'h0, 16'h0, 26'h0003EAE);

    for (int k = 0; k < 16; k++)
      for (int p = 0; p < 3; p++)
        for (int a = 0; a < 6; a++)
          for (int b = 0; b < 6; b += 2)
            for (int m = 0; m < 4; m++)
              runVector(pcs[p], 4'(k), vals[a], vals[b], imms[m],
                        26'(32'h02A5_5A5A ^ (a * 32'h0011_1111) ^ (m * 32'h0100_0001)));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule